// File: doc/BRIEF.md
# Error Address Physical Translator

This block turns the raw address that a DRAM controller reports with a memory error into the system physical address of the failing location. It takes a 28-bit controller-side error address, the channel index that software or a lookup has already resolved, and a valid strobe. It then runs three steps in order. First, it recomputes the four bank bits. The controller stored them in hashed form, and a masked-parity function of the column and row fields undoes that hash. Second, it scatters the corrected address into a normalized address through a fixed bit permutation. Third, it builds the physical address from block, channel and offset fields and folds high physical-address bits into the three channel-select bits.

The result is registered. One cycle after a valid request, `pa_out` and `valid_out` present the translated address. Between requests the last result holds. Every bank-hash enable and mask, and every channel-hash enable, is a parameter so the block can follow other hash settings.

The block contains no state machine. Its only state is the output register pair.

Top module: `ea_phys_xlate`

## Requirements
- R1: `valid_out` equals `valid_in` delayed by one clock. While `rst_n` is low, `valid_out` is 0 and `pa_out` is 0.
- R2: When `valid_in` is low at a clock edge, `pa_out` keeps its previous value.
- R3: Column is `err_addr[5:1]` and row is `err_addr[23:10]`. The four bank bits are recomputed and replace `err_addr[9:6]`. `err_addr[9:6]` is the incoming hashed bank, with bit 6 as bank bit 0.
- R4: Bank bit k equals `err_addr[6+k]` XOR (enable k AND (parity(column AND colmask k) XOR parity(row AND rowmask k))). The defaults are: all four enables set; row masks 0x11111, 0x22222, 0x4444, 0x8888; column masks 0, 0, 0x800, 0x1000. Mask bits above the field width have no effect.
- R5: After the bank fix, error-address bit i for i = 1..27 moves to normalized position P(i), where P = 5,6,8,9,14,12,13,10,11,15,16,...,28 (i = 10..23 map to i+5),24,7,29,30. Bit 0 has no effect.
- R6: Error-address bits 19 and 24 both land on normalized bit 24, and their values are ORed.
- R7: The raw physical address is ((N AND NOT 0xFF) << 7) OR (ch << 8) OR (N AND 0xFF), where N is the normalized address. So `pa_out[4:0]` is 0 and `pa_out[11:8]` equals `ch_idx[3:0]`.
- R8: `pa_out[14:12]` is replaced as follows, with each pa term gated by its size enable. Bit 12 = ch[5]^pa[20]^pa[27]^pa[34]^pa[41]. Bit 13 = ch[6]^pa[21]^pa[28]^pa[35]^pa[42]. Bit 14 = ch[4]^pa[19]^pa[26]^pa[33]^pa[40]^pa[47]. The pa[47] term is disabled by default; the others are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Request strobe |
| err_addr | input | 28 | Controller-side error address |
| ch_idx | input | 8 | Resolved channel index |
| valid_out | output | 1 | Result valid, one cycle after request |
| pa_out | output | 48 | Translated system physical address |

## Verification
Two functions fall in the same cycle: the bank-hash correction and the channel hash. A row bit can flip a bank bit, and the scatter moves that bank bit onto a physical bit that the channel hash reads. One transfer can therefore exercise both, and can also hit the collision on normalized bit 24. The vector table provokes this with hand-computed addresses, for example row bit 9 together with error bits 19 and 24, and judges the full 48-bit result. Random requests are then compared bit for bit against a reference model written from the requirements.

// File: rtl/ea_xlate_pkg.sv
package ea_xlate_pkg;

    localparam int EA_W     = 28;
    localparam int NA_W     = 31;
    localparam int BANK_N   = 4;
    localparam int BANK_LSB = 6;
    localparam int COL_LSB  = 1;
    localparam int COL_W    = 5;
    localparam int ROW_LSB  = 10;
    localparam int ROW_W    = 14;
    localparam int MASK_W   = 32;

    // Normalized position of error-address bit idx (idx 1..27).
    function automatic int na_pos(input int idx);
        case (idx)
            1:  return 5;
            2:  return 6;
            3:  return 8;
            4:  return 9;
            5:  return 14;
            6:  return 12;
            7:  return 13;
            8:  return 10;
            9:  return 11;
            24: return 24;
            25: return 7;
            26: return 29;
            27: return 30;
            default: return idx + 5;
        endcase
    endfunction

endpackage

// File: rtl/ea_bank_fix.sv
module ea_bank_fix
    import ea_xlate_pkg::*;
#(
    parameter logic [BANK_N-1:0]             BANK_EN  = 4'b1111,
    parameter logic [BANK_N-1:0][MASK_W-1:0] COL_MASK = {32'h1000, 32'h800, 32'h0, 32'h0},
    parameter logic [BANK_N-1:0][MASK_W-1:0] ROW_MASK = {32'h8888, 32'h4444, 32'h22222, 32'h11111}
) (
    input  logic [EA_W-1:0] ea_in,
    output logic [EA_W-1:0] ea_fixed
);
    logic [MASK_W-1:0] col_x;
    logic [MASK_W-1:0] row_x;
    logic [BANK_N-1:0] bank;

    assign col_x = MASK_W'(ea_in[COL_LSB +: COL_W]);
    assign row_x = MASK_W'(ea_in[ROW_LSB +: ROW_W]);

    for (genvar k = 0; k < BANK_N; k++) begin : g_bank
        logic par_hit;
        assign par_hit = (^(col_x & COL_MASK[k])) ^ (^(row_x & ROW_MASK[k]));
        assign bank[k] = ea_in[BANK_LSB + k] ^ (BANK_EN[k] & par_hit);
    end

    always_comb begin
        ea_fixed = ea_in;
        ea_fixed[BANK_LSB +: BANK_N] = bank;
    end
endmodule

// File: rtl/ea_scatter.sv
module ea_scatter
    import ea_xlate_pkg::*;
(
    input  logic [EA_W-1:0] ea_in,
    output logic [NA_W-1:0] na_out
);
    logic unused_lsb;
    assign unused_lsb = ea_in[0];

    always_comb begin
        na_out = '0;
        for (int i = 1; i < EA_W; i++) begin
            na_out[na_pos(i)] = na_out[na_pos(i)] | ea_in[i];
        end
    end
endmodule

// File: rtl/pa_chan_hash.sv
module pa_chan_hash
    import ea_xlate_pkg::*;
#(
    parameter int          CH_W    = 8,
    parameter int          PA_W    = 48,
    // {1T, 1G, 2M, 64K, 4K}
    parameter logic [4:0]  HASH_EN = 5'b11110
) (
    input  logic [NA_W-1:0] na_in,
    input  logic [CH_W-1:0] ch_in,
    output logic [PA_W-1:0] pa_out
);
    localparam int BLK_SHIFT = 7;
    localparam int CH_SHIFT  = 8;
    localparam int HASH_LSB  = 12;

    logic [PA_W-1:0] na_x;
    logic [PA_W-1:0] raw;
    logic            h12, h13, h14;

    assign na_x = PA_W'(na_in);
    assign raw  = ((na_x & ~PA_W'(8'hFF)) << BLK_SHIFT)
                | (PA_W'(ch_in) << CH_SHIFT)
                | (na_x & PA_W'(8'hFF));

    assign h12 = ch_in[5] ^ (HASH_EN[1] & raw[20]) ^ (HASH_EN[2] & raw[27])
                          ^ (HASH_EN[3] & raw[34]) ^ (HASH_EN[4] & raw[41]);
    assign h13 = ch_in[6] ^ (HASH_EN[1] & raw[21]) ^ (HASH_EN[2] & raw[28])
                          ^ (HASH_EN[3] & raw[35]) ^ (HASH_EN[4] & raw[42]);
    assign h14 = ch_in[4] ^ (HASH_EN[1] & raw[19]) ^ (HASH_EN[2] & raw[26])
                          ^ (HASH_EN[3] & raw[33]) ^ (HASH_EN[4] & raw[40])
                          ^ (HASH_EN[0] & raw[47]);

    always_comb begin
        pa_out = raw;
        pa_out[HASH_LSB +: 3] = {h14, h13, h12};
    end
endmodule

// File: rtl/ea_phys_xlate.sv
module ea_phys_xlate
    import ea_xlate_pkg::*;
#(
    parameter int                            CH_W     = 8,
    parameter int                            PA_W     = 48,
    parameter logic [BANK_N-1:0]             BANK_EN  = 4'b1111,
    parameter logic [BANK_N-1:0][MASK_W-1:0] COL_MASK = {32'h1000, 32'h800, 32'h0, 32'h0},
    parameter logic [BANK_N-1:0][MASK_W-1:0] ROW_MASK = {32'h8888, 32'h4444, 32'h22222, 32'h11111},
    parameter logic [4:0]                    HASH_EN  = 5'b11110
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_in,
    input  logic [EA_W-1:0] err_addr,
    input  logic [CH_W-1:0] ch_idx,
    output logic            valid_out,
    output logic [PA_W-1:0] pa_out
);
    logic [EA_W-1:0] ea_fixed;
    logic [NA_W-1:0] na;
    logic [PA_W-1:0] pa_next;

    ea_bank_fix #(
        .BANK_EN (BANK_EN),
        .COL_MASK(COL_MASK),
        .ROW_MASK(ROW_MASK)
    ) u_bank (
        .ea_in   (err_addr),
        .ea_fixed(ea_fixed)
    );

    ea_scatter u_scatter (
        .ea_in (ea_fixed),
        .na_out(na)
    );

    pa_chan_hash #(
        .CH_W   (CH_W),
        .PA_W   (PA_W),
        .HASH_EN(HASH_EN)
    ) u_hash (
        .na_in (na),
        .ch_in (ch_idx),
        .pa_out(pa_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            pa_out    <= '0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) begin
                pa_out <= pa_next;
            end
        end
    end
endmodule

// File: rtl/ea_phys_xlate_chk.sv
module ea_phys_xlate_chk #(
    parameter int         CH_W    = 8,
    parameter int         PA_W    = 48,
    parameter logic [4:0] HASH_EN = 5'b11110
) (
    input logic            clk,
    input logic            rst_n,
    input logic            valid_in,
    input logic [CH_W-1:0] ch_idx,
    input logic            valid_out,
    input logic [PA_W-1:0] pa_out
);
    logic unused_pa;
    assign unused_pa = ^pa_out;

    a_r1_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);
    a_r1_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(pa_out));
    a_r7_fields: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> (pa_out[11:8] == $past(ch_idx[3:0])) && (pa_out[4:0] == 5'd0));
    a_r8_ch_bit12: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> pa_out[12] == ($past(ch_idx[5]) ^ (HASH_EN[1] & pa_out[20])
                     ^ (HASH_EN[2] & pa_out[27]) ^ (HASH_EN[3] & pa_out[34])
                     ^ (HASH_EN[4] & pa_out[41])));
    a_r8_ch_bit13: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> pa_out[13] == ($past(ch_idx[6]) ^ (HASH_EN[1] & pa_out[21])
                     ^ (HASH_EN[2] & pa_out[28]) ^ (HASH_EN[3] & pa_out[35])
                     ^ (HASH_EN[4] & pa_out[42])));
    a_r8_ch_bit14: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> pa_out[14] == ($past(ch_idx[4]) ^ (HASH_EN[1] & pa_out[19])
                     ^ (HASH_EN[2] & pa_out[26]) ^ (HASH_EN[3] & pa_out[33])
                     ^ (HASH_EN[4] & pa_out[40]) ^ (HASH_EN[0] & pa_out[47])));
endmodule

bind ea_phys_xlate ea_phys_xlate_chk #(
    .CH_W   (CH_W),
    .PA_W   (PA_W),
    .HASH_EN(HASH_EN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_in (valid_in),
    .ch_idx   (ch_idx),
    .valid_out(valid_out),
    .pa_out   (pa_out)
);

// File: tb/tb_ea_phys_xlate.sv
module tb_ea_phys_xlate;
    localparam int NV = 12;
    // {err_addr[27:0], ch[7:0], expected pa[47:0]}
    localparam logic [83:0] VEC [NV] = '{
        {28'h0000000, 8'h00, 48'h000000000000},
        {28'h0000000, 8'h10, 48'h000000004000},
        {28'h0000002, 8'h00, 48'h000000000020},
        {28'h0000400, 8'h00, 48'h000000484000},
        {28'h0000040, 8'h00, 48'h000000084000},
        {28'h1080000, 8'h00, 48'h000080101000},
        {28'h1000000, 8'h00, 48'h000080000000},
        {28'h0000001, 8'h00, 48'h000000000000},
        {28'h0000000, 8'h20, 48'h000000001000},
        {28'h0000000, 8'h40, 48'h000000002000},
        {28'h0000000, 8'h80, 48'h000000008000},
        {28'h0200000, 8'h00, 48'h000200044000}
    };
    localparam int MAPV [28] = '{0, 5, 6, 8, 9, 14, 12, 13, 10, 11, 15, 16, 17, 18,
                                 19, 20, 21, 22, 23, 24, 25, 26, 27, 28, 24, 7, 29, 30};
    localparam logic [31:0] RMASK [4] = '{32'h11111, 32'h22222, 32'h4444, 32'h8888};
    localparam logic [31:0] CMASK [4] = '{32'h0, 32'h0, 32'h800, 32'h1000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [27:0] err_addr = '0;
    logic [7:0]  ch_idx = '0;
    logic        valid_out;
    logic [47:0] pa_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    ea_phys_xlate dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .err_addr(err_addr),
        .ch_idx(ch_idx), .valid_out(valid_out), .pa_out(pa_out)
    );

    function automatic logic [47:0] ref_pa(input logic [27:0] ea, input logic [7:0] ch);
        logic [31:0] col, row;
        logic [27:0] e;
        logic [30:0] na;
        logic [47:0] p;
        col = 32'(ea[5:1]);
        row = 32'(ea[23:10]);
        e = ea;
        for (int k = 0; k < 4; k++)
            e[6+k] = ea[6+k] ^ ((^(col & CMASK[k])) ^ (^(row & RMASK[k])));
        na = '0;
        for (int i = 1; i < 28; i++) na[MAPV[i]] = na[MAPV[i]] | e[i];
        p = ((48'(na) & ~48'hFF) << 7) | (48'(ch) << 8) | (48'(na) & 48'hFF);
        p[12] = ch[5] ^ p[20] ^ p[27] ^ p[34] ^ p[41];
        p[13] = ch[6] ^ p[21] ^ p[28] ^ p[35] ^ p[42];
        p[14] = ch[4] ^ p[19] ^ p[26] ^ p[33] ^ p[40];
        return p;
    endfunction

    task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic send(input logic [27:0] ea, input logic [7:0] ch);
        @(negedge clk);
        valid_in = 1'b1;
        err_addr = ea;
        ch_idx = ch;
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("[TB] FAIL watchdog got=%h exp=%h", 1'b1, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [47:0] last;
        logic [27:0] rea;
        logic [7:0]  rch;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset valid", 48'(valid_out), 48'h0);
        check("R1 reset pa", pa_out, 48'h0);
        rst_n = 1'b1;

        // Vector table: R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            send(VEC[v][83:56], VEC[v][55:48]);
            check("R1 valid_out after request", 48'(valid_out), 48'h1);
            check($sformatf("R3 R4 R5 R6 R7 R8 vector %0d", v), pa_out, VEC[v][47:0]);
        end

        // R6: bits 19 and 24 alone land on the same normalized bit
        send(28'h0080000, 8'h00);
        last = pa_out;
        send(28'h1000000, 8'h00);
        check("R6 bit24 sets pa31", 48'(pa_out[31]), 48'h1);
        check("R6 bit19 sets pa31", 48'(last[31]), 48'h1);

        // R2: hold when idle, inputs changing
        send(28'h0ABCDEF, 8'h5A);
        last = pa_out;
        @(negedge clk);
        err_addr = 28'h5555555;
        ch_idx = 8'hFF;
        @(negedge clk);
        @(negedge clk);
        check("R2 hold pa", pa_out, last);
        check("R1 idle valid low", 48'(valid_out), 48'h0);

        // R1: back-to-back requests
        @(negedge clk);
        valid_in = 1'b1;
        err_addr = 28'h0000400;
        ch_idx = 8'h00;
        @(negedge clk);
        check("R1 back-to-back first", pa_out, 48'h000000484000);
        err_addr = 28'h0000002;
        @(negedge clk);
        valid_in = 1'b0;
        check("R1 back-to-back second", pa_out, 48'h000000000020);

        // Random comparison against reference: R4 R5 R7 R8
        for (int r = 0; r < 300; r++) begin
            rea = 28'($urandom);
            rch = 8'($urandom);
            send(rea, rch);
            check("R4 R5 R7 R8 random", pa_out, ref_pa(rea, rch));
        end

        // R1: reset mid-run clears the result
        send(28'h0200000, 8'h33);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async reset pa", pa_out, 48'h0);
        check("R1 async reset valid", 48'(valid_out), 48'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule